// File: doc/BRIEF.md
# Four-Channel Compare Timer

This block is the system tick source of a processor subsystem. One 32-bit up-counter advances on each cycle in which the tick-enable input is high, so the count rate can be any fraction of the bus clock. The counter wraps modulo 2^32. Four compare channels each hold a 32-bit target value. When the counter steps onto a channel's target, that channel's sticky status flag sets. A per-channel enable bit passes the flag to that channel's interrupt line.

Software reaches the block through a word-indexed register bus. Writes take one cycle. Read data is registered and appears one cycle after the read strobe. The counter can be written. A one-shot event is therefore set up by reading the count, writing count plus a delay into a compare register, and setting the channel's enable. The handler acknowledges the event by writing a 1 to the channel's status bit.

Channel 3 can also act as a watchdog. Once its arming bit is set, a channel-3 event raises a reset request that stays high until system reset.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset, the counter, all compare registers, all status flags, the interrupt enables, the watchdog arming bit and `wdog_rst` are all 0.
- R2: Word index 0..3 selects compare registers 0..3, index 4 the counter, 5 the status flags (bits 3:0), 6 the watchdog arming bit (bit 0) and 7 the interrupt enables (bits 3:0). Read data appears on `bus_rdata` one cycle after `bus_rd`. Compare registers and enables read back as written.
- R3: A status write clears each flag whose data bit is 1 and leaves alone each flag whose data bit is 0.
- R4: A counter write loads the written value. If a write and a tick happen in the same cycle, the write wins and the tick is dropped.
- R5: Each tick without a counter write adds one to the counter modulo 2^32. Without a tick the counter holds.
- R6: Channel n's flag (status bit n) sets on the edge where a tick moves the counter onto that channel's compare value, including onto values just past the wrap. Loading the counter by a write never sets a flag. A set and a clear in the same cycle leave the flag set, and the flag otherwise stays set until cleared.
- R7: `irq[n]` is high exactly when flag n and enable bit n are both 1. Clearing the enable bit drops the line without changing the compare register.
- R8: Writing 1 to bit 0 of the watchdog register arms the watchdog. Writing 0 has no effect, and only reset disarms it.
- R9: `wdog_rst` rises on the edge where channel 3's flag sets while the watchdog is armed, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable |
| bus_addr | input | 3 | Word index of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-channel interrupt lines |
| wdog_rst | output | 1 | Sticky watchdog reset request |

## Verification
An internal counter that drifts by even one count shows up the next time the counter register is read back. It also moves the edge at which a compare flag sets, and that shows on `irq` one clock after the faulty step. A flag that sets wrongly, or fails to clear, is visible on the status register and, when enabled, on `irq` in the very next cycle. A watchdog arming bit that loses its stickiness is visible on its readback right after a write of 0. Because the reset request can never fall, a spurious `wdog_rst` stays visible until reset.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int DATA_W  = 32;
    localparam int NUM_CH  = 4;
    localparam int IDX_W   = 3;
    localparam int WDOG_CH = NUM_CH - 1;

    typedef enum logic [IDX_W-1:0] {
        SEL_CMP0 = 3'd0,
        SEL_CMP1 = 3'd1,
        SEL_CMP2 = 3'd2,
        SEL_CMP3 = 3'd3,
        SEL_CNT  = 3'd4,
        SEL_STAT = 3'd5,
        SEL_WDOG = 3'd6,
        SEL_IEN  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_idx(input logic [IDX_W-1:0] idx);
        return reg_sel_e'(idx);
    endfunction

    function automatic logic is_cmp_sel(input reg_sel_e s, input int ch);
        return (int'(s) == ch) && (ch < NUM_CH);
    endfunction
endpackage

// File: rtl/mt_counter.sv
module mt_counter
    import mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] cnt_next,
    output logic              adv
);
    assign adv      = tick && !load;
    assign cnt_next = cnt_q + DATA_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (adv)  cnt_q <= cnt_next;
    end

    // R4: a write loads the value, even against a tick
    a_r4_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(load_val));
    // R5: tick increments modulo 2^32
    a_r5_tick_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> cnt_q == $past(cnt_q) + DATA_W'(1));
    // R5: no tick, no write: counter holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/mt_channel.sv
module mt_channel
    import mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [DATA_W-1:0] cnt_next,
    input  logic              cmp_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr,
    input  logic              irq_en,
    output logic [DATA_W-1:0] cmp_q,
    output logic              flag_q,
    output logic              hit,
    output logic              irq
);
    assign hit = adv && (cnt_next == cmp_q);
    assign irq = flag_q && irq_en;

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '0;
        else if (cmp_wr) cmp_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    // R6: stepping onto the compare value sets the flag
    a_r6_set_on_hit: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);
    // R6: flag is sticky without a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);
    // R6: no advance means no new flag
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!adv && !flag_q) |=> !flag_q);
    // R3: clear without a simultaneous hit empties the flag
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag_q);
endmodule

// File: rtl/mt_regfile.sv
module mt_regfile
    import mt_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  bus_req_t                       req,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  cmp_vals,
    input  logic [DATA_W-1:0]              cnt,
    input  logic [NUM_CH-1:0]              flags,
    output logic [NUM_CH-1:0]              cmp_wr,
    output logic                           cnt_load,
    output logic [NUM_CH-1:0]              clr,
    output logic [NUM_CH-1:0]              ien_q,
    output logic                           wden_q,
    output logic [DATA_W-1:0]              rdata
);
    logic [DATA_W-1:0] rd_mux;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp_dec
        assign cmp_wr[g] = req.wr && is_cmp_sel(req.sel, g);
    end

    assign cnt_load = req.wr && (req.sel == SEL_CNT);
    assign clr      = (req.wr && (req.sel == SEL_STAT)) ? req.wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)                                ien_q <= '0;
        else if (req.wr && req.sel == SEL_IEN)  ien_q <= req.wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                                             wden_q <= 1'b0;
        else if (req.wr && req.sel == SEL_WDOG && req.wdata[0]) wden_q <= 1'b1;
    end

    always_comb begin
        rd_mux = '0;
        case (req.sel)
            SEL_CMP0: rd_mux = cmp_vals[0];
            SEL_CMP1: rd_mux = cmp_vals[1];
            SEL_CMP2: rd_mux = cmp_vals[2];
            SEL_CMP3: rd_mux = cmp_vals[3];
            SEL_CNT:  rd_mux = cnt;
            SEL_STAT: rd_mux = DATA_W'(flags);
            SEL_WDOG: rd_mux = DATA_W'(wden_q);
            SEL_IEN:  rd_mux = DATA_W'(ien_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= rd_mux;
    end

    // R8: arming bit can only be cleared by reset
    a_r8_arm_sticky: assert property (@(posedge clk) disable iff (rst)
        wden_q |=> wden_q);
    // R2: read data is the counter value sampled at the strobe
    a_r2_cnt_read: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == SEL_CNT) |=> rdata == $past(cnt));
endmodule

// File: rtl/match_timer.sv
module match_timer
    import mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq,
    output logic              wdog_rst
);
    bus_req_t                      req;
    logic [NUM_CH-1:0][DATA_W-1:0] cmp_vals;
    logic [DATA_W-1:0]             cnt_q;
    logic [DATA_W-1:0]             cnt_next;
    logic                          adv;
    logic [NUM_CH-1:0]             flags;
    logic [NUM_CH-1:0]             hits;
    logic [NUM_CH-1:0]             cmp_wr;
    logic                          cnt_load;
    logic [NUM_CH-1:0]             clr;
    logic [NUM_CH-1:0]             ien_q;
    logic                          wden_q;

    assign req.wr    = bus_wr;
    assign req.rd    = bus_rd;
    assign req.sel   = decode_idx(bus_addr);
    assign req.wdata = bus_wdata;

    mt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .adv      (adv)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mt_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .adv      (adv),
            .cnt_next (cnt_next),
            .cmp_wr   (cmp_wr[g]),
            .wdata    (bus_wdata),
            .clr      (clr[g]),
            .irq_en   (ien_q[g]),
            .cmp_q    (cmp_vals[g]),
            .flag_q   (flags[g]),
            .hit      (hits[g]),
            .irq      (irq[g])
        );
    end

    mt_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cmp_vals (cmp_vals),
        .cnt      (cnt_q),
        .flags    (flags),
        .cmp_wr   (cmp_wr),
        .cnt_load (cnt_load),
        .clr      (clr),
        .ien_q    (ien_q),
        .wden_q   (wden_q),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)                            wdog_rst <= 1'b0;
        else if (wden_q && hits[WDOG_CH])   wdog_rst <= 1'b1;
    end

    // R9: reset request never falls on its own
    a_r9_wdog_sticky: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |=> wdog_rst);
    // R9: armed watchdog channel event raises the request
    a_r9_wdog_fire: assert property (@(posedge clk) disable iff (rst)
        (wden_q && hits[WDOG_CH]) |=> wdog_rst);
    // R7: an interrupt line needs its enable and its flag
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (irq & ~(ien_q & flags)) == '0);
endmodule

// File: tb/match_timer_bench.sv
module match_timer_bench;
    import mt_pkg::*;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam logic [1:0] OP_CK = 2'd3;
    localparam int NV = 52;

    // {op, idx, data, expected, requirement}
    localparam logic [72:0] VEC [0:NV-1] = '{
        {OP_RD, 3'd4, 32'd0, 32'd0, 4'd1},            // R1 counter
        {OP_RD, 3'd5, 32'd0, 32'd0, 4'd1},            // R1 status
        {OP_RD, 3'd7, 32'd0, 32'd0, 4'd1},            // R1 enables
        {OP_RD, 3'd6, 32'd0, 32'd0, 4'd1},            // R1 arming
        {OP_RD, 3'd0, 32'd0, 32'd0, 4'd1},            // R1 compare
        {OP_CK, 3'd0, 32'd0, 32'd0, 4'd1},            // R1 outputs
        {OP_WR, 3'd0, 32'd5, 32'd0, 4'd2},
        {OP_WR, 3'd1, 32'd10, 32'd0, 4'd2},
        {OP_RD, 3'd0, 32'd0, 32'd5, 4'd2},            // R2 readback
        {OP_RD, 3'd1, 32'd0, 32'd10, 4'd2},
        {OP_TK, 3'd0, 32'd5, 32'd0, 4'd5},
        {OP_RD, 3'd5, 32'd0, 32'd1, 4'd6},            // R6 ch0 hit
        {OP_RD, 3'd4, 32'd0, 32'd5, 4'd5},            // R5 count
        {OP_WR, 3'd7, 32'd1, 32'd0, 4'd7},
        {OP_CK, 3'd0, 32'd0, 32'd1, 4'd7},            // R7 irq0
        {OP_WR, 3'd5, 32'd2, 32'd0, 4'd3},
        {OP_RD, 3'd5, 32'd0, 32'd1, 4'd3},            // R3 zero bit ignored
        {OP_WR, 3'd5, 32'd1, 32'd0, 4'd3},
        {OP_RD, 3'd5, 32'd0, 32'd0, 4'd3},            // R3 cleared
        {OP_CK, 3'd0, 32'd0, 32'd0, 4'd7},
        {OP_TK, 3'd0, 32'd5, 32'd0, 4'd5},
        {OP_RD, 3'd5, 32'd0, 32'd2, 4'd6},            // R6 ch1 hit
        {OP_CK, 3'd0, 32'd0, 32'd0, 4'd7},            // R7 disabled
        {OP_WR, 3'd7, 32'd3, 32'd0, 4'd7},
        {OP_CK, 3'd0, 32'd0, 32'd2, 4'd7},
        {OP_WR, 3'd7, 32'd1, 32'd0, 4'd7},
        {OP_CK, 3'd0, 32'd0, 32'd0, 4'd7},            // R7 disarm
        {OP_RD, 3'd1, 32'd0, 32'd10, 4'd7},           // R7 compare kept
        {OP_RD, 3'd7, 32'd0, 32'd1, 4'd2},
        {OP_WR, 3'd3, 32'h100, 32'd0, 4'd2},
        {OP_WR, 3'd4, 32'hFFFF_FFFE, 32'd0, 4'd4},
        {OP_WR, 3'd2, 32'd1, 32'd0, 4'd2},
        {OP_TK, 3'd0, 32'd3, 32'd0, 4'd5},
        {OP_RD, 3'd4, 32'd0, 32'd1, 4'd5},            // R5 wrap
        {OP_RD, 3'd5, 32'd0, 32'd6, 4'd6},            // R6 across wrap
        {OP_WR, 3'd4, 32'h100, 32'd0, 4'd4},
        {OP_RD, 3'd5, 32'd0, 32'd6, 4'd6},            // R6 load never sets
        {OP_TK, 3'd0, 32'd1, 32'd0, 4'd5},
        {OP_RD, 3'd4, 32'd0, 32'h101, 4'd4},          // R4 continue from load
        {OP_WR, 3'd6, 32'd1, 32'd0, 4'd8},
        {OP_RD, 3'd6, 32'd0, 32'd1, 4'd8},            // R8 armed
        {OP_WR, 3'd6, 32'd0, 32'd0, 4'd8},
        {OP_RD, 3'd6, 32'd0, 32'd1, 4'd8},            // R8 zero ignored
        {OP_CK, 3'd0, 32'd0, 32'd0, 4'd9},
        {OP_WR, 3'd4, 32'hFF, 32'd0, 4'd9},
        {OP_TK, 3'd0, 32'd1, 32'd0, 4'd9},
        {OP_CK, 3'd0, 32'd0, 32'h10, 4'd9},           // R9 fired
        {OP_RD, 3'd5, 32'd0, 32'hE, 4'd6},
        {OP_WR, 3'd5, 32'hF, 32'd0, 4'd3},
        {OP_CK, 3'd0, 32'd0, 32'h10, 4'd9},           // R9 sticky
        {OP_RD, 3'd5, 32'd0, 32'd0, 4'd3},
        {OP_RD, 3'd3, 32'd0, 32'h100, 4'd2}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic [IDX_W-1:0]  bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NUM_CH-1:0] irq;
    logic              wdog_rst;
    int                n_chk = 0;
    int                n_err = 0;

    always #2 clk = ~clk;

    match_timer u_match_timer (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input int req);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [2:0]  ix;
            logic [31:0] dt, ex;
            int          rq;
            op = VEC[i][72:71]; ix = VEC[i][70:68];
            dt = VEC[i][67:36]; ex = VEC[i][35:4]; rq = int'(VEC[i][3:0]);
            case (op)
                OP_WR: wr(ix, dt);
                OP_RD: rd(ix, ex, rq);
                OP_TK: begin
                    tick = 1'b1;
                    repeat (int'(dt)) @(negedge clk);
                    tick = 1'b0;
                end
                default: check(rq, {27'd0, wdog_rst, irq}, ex);
            endcase
        end

        // R4: write and tick in one cycle, write wins
        tick = 1'b1;
        wr(3'd4, 32'd50);
        tick = 1'b0;
        rd(3'd4, 32'd50, 4);

        // R6: set beats a simultaneous clear
        wr(3'd0, 32'd60);
        wr(3'd4, 32'd59);
        tick = 1'b1;
        wr(3'd5, 32'd1);
        tick = 1'b0;
        rd(3'd5, 32'd1, 6);
        rd(3'd4, 32'd60, 5);
        check(7, {27'd0, wdog_rst, irq}, 32'h11);

        // R1: reset clears everything, including the sticky request
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(1, {27'd0, wdog_rst, irq}, 32'd0);
        for (int a = 0; a < 8; a++) rd(3'(a), 32'd0, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule